// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block is the control core of a behavioural model of an address-multiplexed DRAM. A fast clock samples the active-low row strobe, column strobe, write enable and output enable. The block classifies every row-strobe period as a read, an early write, a late write (delayed write or read-modify-write), a row-only refresh, a column-before-row refresh or a hidden refresh. From that it derives the row and column latch behaviour, the write strobe and which pin timed it, the output-driver enable, and the row to open: either the multiplexed address pins or an internal refresh row counter.

Strobe edges are found by comparing each sampled pin with its value one clock earlier. An edge seen at a clock edge updates the registered outputs at that same edge. A storage array, sense timing and data pins sit outside the block. A model wraps the decoder with an array that is written on `wr_stb` and read at `row_addr`/`col_addr`.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After synchronous reset, `row_le`, `wr_stb`, `dq_oe` and `cyc_stb` are 0, `row_addr` and `col_addr` are 0, and the refresh row counter is 0.
- R2: A row strobe fall while the column strobe is high pulses `row_le` for one clock and loads `row_addr` from `addr`.
- R3: A row strobe fall while the column strobe is already low is a column-before-row refresh. `row_addr` takes the refresh counter value and ignores `addr`, `dq_oe` stays 0, and the cycle is reported as kind 5. The column strobe may stay low over back-to-back refreshes, and each one takes the next row.
- R4: A row strobe period in which the column strobe never falls is reported as kind 4 (row-only refresh), with `dq_oe` held at 0 even when output enable is low.
- R5: If the column strobe stays low after a read (or a hidden refresh) and the row strobe falls again, the cycle is a hidden refresh, reported as kind 6. It uses the counter row, and `dq_oe` keeps driving.
- R6: A column strobe fall while write enable is low is an early write. It gives a one-clock `wr_stb` with `wr_by_we`=0, it is reported as kind 2, and `dq_oe` stays 0.
- R7: A write-enable fall while the column strobe is low after a read gives a one-clock `wr_stb` with `wr_by_we`=1, and the cycle is reported as kind 3.
- R8: A column strobe fall with write enable high is a read, reported as kind 1. `dq_oe` is 1 only while the column strobe and output enable are both low after such a read. It drops one clock after either one rises.
- R9: During an access cycle, `col_addr` follows `addr` while the column strobe is high. It captures at the column strobe fall and holds while that strobe is low. A later column strobe rise inside the same row period reopens it (page mode).
- R10: The refresh counter is 9 bits wide (`AW`). It advances by one at the end of each column-before-row or hidden refresh and wraps from 511 to 0.
- R11: `cyc_stb` pulses for one clock at each row strobe rise, with `cyc_kind` holding the code of the period just ended (1 read, 2 early write, 3 late write, 4 row-only, 5 column-before-row, 6 hidden).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address pins |
| row_le | output | 1 | One-clock pulse when a row is opened |
| row_addr | output | AW | Row opened or refreshed |
| col_addr | output | AW | Column latch contents |
| wr_stb | output | 1 | One-clock write strobe |
| wr_by_we | output | 1 | 1 when the last write strobe came from write enable, 0 from the column strobe |
| dq_oe | output | 1 | Output driver enable |
| cyc_stb | output | 1 | One-clock cycle report strobe |
| cyc_kind | output | 3 | Code of the reported cycle |

## Verification
On every clock the embedded properties check three things: cycle reports and row opens are single-clock pulses, the output enable is never raised unless both the column strobe and output enable were low, and an early write never drives. They also check that every write strobe coincides with write enable low and that each refresh report comes with exactly one counter step. The classification itself needs the bench's scenarios: telling hidden refresh from column-before-row refresh, early from late writes, and row-only cycles from reads. So do the column latch reopening in page mode, the row source per cycle kind, and the counter wrap.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_READ  = 3'd1,
    K_EWR   = 3'd2,
    K_LWR   = 3'd3,
    K_RONLY = 3'd4,
    K_CBR   = 3'd5,
    K_HID   = 3'd6
  } cyc_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACC  = 2'd1,
    PH_REF  = 2'd2
  } phase_e;
endpackage

// File: rtl/dram_strobe_sampler.sv
module dram_strobe_sampler #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  // Strobes are active low, so the idle value after reset is all ones.
  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= cur;
  end
endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  // Natural binary wrap from all ones to zero.
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dram_cycle_fsm.sv
module dram_cycle_fsm
  import dram_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       oe_n,
  input  logic       p_ras,
  input  logic       p_cas,
  input  logic       p_we,
  output logic       row_ld,
  output logic       row_from_ctr,
  output logic       col_ld,
  output logic       ctr_inc,
  output logic       wr_stb,
  output logic       wr_by_we,
  output logic       dq_oe,
  output logic       cyc_stb,
  output logic [2:0] cyc_kind
);
  phase_e    phase;
  cyc_kind_e acc_kind;
  cyc_kind_e kind_q;
  logic      rd_valid, hide_ok, hidden;
  logic      ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic      rd_nxt;

  always_comb begin
    ras_fall = p_ras & ~ras_n;
    ras_rise = ~p_ras & ras_n;
    cas_fall = p_cas & ~cas_n;
    cas_rise = ~p_cas & cas_n;
    we_fall  = p_we & ~we_n;
    row_ld       = ras_fall;
    row_from_ctr = ras_fall & ~cas_n;
    col_ld       = ~ras_n & p_cas & ((phase == PH_ACC) | (ras_fall & cas_n));
    ctr_inc      = ras_rise & (phase == PH_REF);
    rd_nxt = rd_valid;
    if (cas_rise)
      rd_nxt = 1'b0;
    else if ((phase == PH_ACC) && cas_fall && ~ras_n)
      rd_nxt = we_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      acc_kind <= K_NONE;
      kind_q   <= K_NONE;
      rd_valid <= 1'b0;
      hide_ok  <= 1'b0;
      hidden   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_by_we <= 1'b0;
      dq_oe    <= 1'b0;
      cyc_stb  <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      cyc_stb  <= 1'b0;
      rd_valid <= rd_nxt;
      dq_oe    <= rd_nxt & ~cas_n & ~oe_n;
      if (cas_rise) hide_ok <= 1'b0;
      if (ras_fall) begin
        if (cas_n) begin
          phase    <= PH_ACC;
          acc_kind <= K_NONE;
        end else begin
          phase  <= PH_REF;
          hidden <= hide_ok;
        end
      end else if (ras_rise) begin
        cyc_stb <= 1'b1;
        if (phase == PH_REF)
          kind_q <= hidden ? K_HID : K_CBR;
        else
          kind_q <= (acc_kind == K_NONE) ? K_RONLY : acc_kind;
        hide_ok <= ~cas_n & (((phase == PH_ACC) && (acc_kind == K_READ)) ||
                             ((phase == PH_REF) && hidden));
        phase <= PH_IDLE;
      end else if ((phase == PH_ACC) && ~ras_n) begin
        if (cas_fall) begin
          acc_kind <= we_n ? K_READ : K_EWR;
          wr_stb   <= ~we_n;
          wr_by_we <= 1'b0;
        end else if (we_fall && ~cas_n && (acc_kind == K_READ)) begin
          acc_kind <= K_LWR;
          wr_stb   <= 1'b1;
          wr_by_we <= 1'b1;
        end
      end
    end
  end

  assign cyc_kind = kind_q;

  // R11: a report is a single-clock pulse
  a_r11_stb_pulse: assert property (@(posedge clk) disable iff (rst)
    cyc_stb |=> !cyc_stb);
  // R8: drivers only follow column strobe and output enable both low
  a_r8_oe_needs_both: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!$past(cas_n) && !$past(oe_n)));
  // R6: an early write never drives the outputs
  a_r6_early_quiet: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !wr_by_we) |-> !dq_oe);
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dram_dec_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  output logic          row_le,
  output logic [AW-1:0] row_addr,
  output logic [AW-1:0] col_addr,
  output logic          wr_stb,
  output logic          wr_by_we,
  output logic          dq_oe,
  output logic          cyc_stb,
  output logic [2:0]    cyc_kind
);
  localparam int NSTB = 3;

  logic [NSTB-1:0] cur_stb, prev_stb;
  logic [AW-1:0]   rf_cnt;
  logic            row_ld, row_from_ctr, col_ld, ctr_inc;

  assign cur_stb = {we_n, cas_n, ras_n};

  dram_strobe_sampler #(.N(NSTB)) u_sample (
    .clk (clk), .rst (rst), .cur (cur_stb), .prev (prev_stb)
  );

  dram_refresh_ctr #(.W(AW)) u_rfctr (
    .clk (clk), .rst (rst), .inc (ctr_inc), .cnt (rf_cnt)
  );

  dram_cycle_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .oe_n         (oe_n),
    .p_ras        (prev_stb[0]),
    .p_cas        (prev_stb[1]),
    .p_we         (prev_stb[2]),
    .row_ld       (row_ld),
    .row_from_ctr (row_from_ctr),
    .col_ld       (col_ld),
    .ctr_inc      (ctr_inc),
    .wr_stb       (wr_stb),
    .wr_by_we     (wr_by_we),
    .dq_oe        (dq_oe),
    .cyc_stb      (cyc_stb),
    .cyc_kind     (cyc_kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_le   <= 1'b0;
      row_addr <= '0;
      col_addr <= '0;
    end else begin
      row_le <= row_ld;
      if (row_ld) row_addr <= row_from_ctr ? rf_cnt : addr;
      if (col_ld) col_addr <= addr;
    end
  end

  // R2: a row open is a single-clock pulse
  a_r2_row_le_pulse: assert property (@(posedge clk) disable iff (rst)
    row_le |=> !row_le);
  // R7: every write strobe coincides with write enable low
  a_r7_wr_we_low: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !$past(we_n));
  // R10: each refresh report comes with one counter step
  a_r10_ctr_step: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && (cyc_kind == K_CBR || cyc_kind == K_HID)) |->
      (rf_cnt == AW'($past(rf_cnt) + 1'b1)));
endmodule

// File: tb/test_dram_strobe_decoder.sv
module test_dram_strobe_decoder;
  localparam int AW = 9;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          row_le, wr_stb, wr_by_we, dq_oe, cyc_stb;
  logic [AW-1:0] row_addr, col_addr;
  logic [2:0]    cyc_kind;

  int checks = 0, fails = 0, exp_ctr = 0, e;
  int kq[$];
  int rq[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  dram_strobe_decoder #(.AW(AW)) i_dram_strobe_decoder (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .row_le(row_le), .row_addr(row_addr),
    .col_addr(col_addr), .wr_stb(wr_stb), .wr_by_we(wr_by_we),
    .dq_oe(dq_oe), .cyc_stb(cyc_stb), .cyc_kind(cyc_kind)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  // Monitor: pops expected cycle kinds and opened rows as they appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (cyc_stb) begin
        if (kq.size() == 0) chk("R11 unexpected report", 1, 0);
        else begin e = kq.pop_front(); chk("R11 cycle kind", int'(cyc_kind), e); end
      end
      if (row_le) begin
        if (rq.size() == 0) chk("R2 unexpected row open", 1, 0);
        else begin e = rq.pop_front(); chk("R2 row address", int'(row_addr), e); end
      end
    end
  end

  task automatic read_cyc(input int row, input int col, input bit hold_cas);
    addr = AW'(row); ras_n = 0; rq.push_back(row); tick;
    addr = AW'(col); tick; chk("R9 column follows pins", col_addr, col);
    cas_n = 0; oe_n = 0; kq.push_back(1); tick;
    chk("R8 drive with CAS and G low", dq_oe, 1);
    addr = AW'(~col); tick; chk("R9 column held", col_addr, col);
    oe_n = 1; tick; chk("R8 G high disables", dq_oe, 0);
    oe_n = 0; tick; chk("R8 G low re-enables", dq_oe, 1);
    ras_n = 1; tick;
    if (!hold_cas) begin
      cas_n = 1; tick; chk("R8 CAS high disables", dq_oe, 0);
      oe_n = 1;
    end
  endtask

  task automatic cbr_cyc;
    ras_n = 0; rq.push_back(exp_ctr); tick;
    chk("R3 refresh keeps outputs off", dq_oe, 0);
    ras_n = 1; kq.push_back(5); exp_ctr = (exp_ctr + 1) % 512; tick;
  endtask

  task automatic hidden_cyc;
    addr = '1; ras_n = 0; rq.push_back(exp_ctr); kq.push_back(6); tick;
    chk("R5 output held in hidden refresh", dq_oe, 1);
    tick;
    ras_n = 1; exp_ctr = (exp_ctr + 1) % 512; tick;
    chk("R5 output held after hidden refresh", dq_oe, 1);
  endtask

  initial begin
    repeat (4) tick;
    rst = 0;
    chk("R1 row_le", row_le, 0);
    chk("R1 wr_stb", wr_stb, 0);
    chk("R1 dq_oe", dq_oe, 0);
    chk("R1 cyc_stb", cyc_stb, 0);
    chk("R1 row_addr", row_addr, 0);
    chk("R1 col_addr", col_addr, 0);
    tick;

    read_cyc(9'h0A5, 9'h013, 0);

    // Early write
    addr = 9'h1F0; ras_n = 0; rq.push_back(9'h1F0); tick;
    addr = 9'h0AA; we_n = 0; oe_n = 0; tick;
    cas_n = 0; kq.push_back(2); tick;
    chk("R6 early write strobe", wr_stb, 1);
    chk("R6 strobe from column strobe", wr_by_we, 0);
    chk("R6 no drive", dq_oe, 0);
    tick; chk("R6 strobe is one clock", wr_stb, 0);
    chk("R6 still no drive", dq_oe, 0);
    ras_n = 1; tick;
    cas_n = 1; we_n = 1; oe_n = 1; tick;

    // Delayed write
    addr = 9'h033; ras_n = 0; rq.push_back(9'h033); tick;
    addr = 9'h101; tick;
    cas_n = 0; tick; chk("R7 no strobe before W falls", wr_stb, 0);
    we_n = 0; kq.push_back(3); tick;
    chk("R7 late write strobe", wr_stb, 1);
    chk("R7 strobe from write enable", wr_by_we, 1);
    ras_n = 1; tick;
    cas_n = 1; we_n = 1; tick;

    // Row-only refresh
    addr = 9'h155; oe_n = 0; ras_n = 0; rq.push_back(9'h155); kq.push_back(4); tick;
    chk("R4 row-only keeps outputs off", dq_oe, 0);
    tick; ras_n = 1; tick;
    chk("R4 row-only off at end", dq_oe, 0);

    // Column-before-row refresh, column strobe held low throughout
    cas_n = 0; addr = 9'h0F0; tick;
    for (int i = 0; i < 3; i++) cbr_cyc;
    cas_n = 1; oe_n = 1; tick;

    // Hidden refresh after a read
    read_cyc(9'h07E, 9'h0C3, 1);
    hidden_cyc;
    hidden_cyc;
    cas_n = 1; oe_n = 1; tick;
    chk("R5 drivers off after column strobe rises", dq_oe, 0);

    // Page mode column reopening
    addr = 9'h1AB; ras_n = 0; rq.push_back(9'h1AB); tick;
    addr = 9'h011; tick;
    cas_n = 0; tick; chk("R9 first column captured", col_addr, 9'h011);
    cas_n = 1; addr = 9'h122; tick; tick;
    chk("R9 page reopen follows pins", col_addr, 9'h122);
    cas_n = 0; tick; addr = '0; tick;
    chk("R9 second column held", col_addr, 9'h122);
    ras_n = 1; kq.push_back(1); tick;
    cas_n = 1; tick;

    // Counter wrap
    cas_n = 0; tick;
    while (exp_ctr != 511) cbr_cyc;
    cbr_cyc;
    chk("R10 counter model wrapped", exp_ctr, 0);
    ras_n = 0; rq.push_back(0); tick;
    chk("R10 row after wrap", row_addr, 0);
    ras_n = 1; kq.push_back(5); exp_ctr = 1; tick;
    cas_n = 1; tick;

    repeat (3) tick;
    chk("R11 all cycles reported", kq.size(), 0);
    chk("R2 all rows opened", rq.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule